// File: doc/BRIEF.md
# Read-Set Mark Filter

This block helps a software transaction keep its read set small. Each time the read instrumentation is about to log a cache block, it first sends the block address here. The block keeps one mark bit per tracked cache block for the thread that is running now. It answers whether the block was already marked and has not been lost since. If so, software can skip logging that block again. The request then marks the block.

A snoop input reports remote writes and evictions. Either event on a marked block drops the mark and raises a sticky "possibly written" flag. Any event that loses tracking state also raises this flag. That covers a context switch and a tag conflict that pushes out a marked entry. Software reads the flag with a query. If the flag is set, the transaction must validate its read set in software. A clear command resets every mark and the flag in one cycle when a new transaction begins.

Addresses arrive as block numbers, with the 64-byte byte offset already removed. A direct-mapped table holds 64 entries. The low block-number bits select the entry and the remaining bits form the stored tag.

Top module: `rsf_readset_filter`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid`, `qry_ack` and `qry_dirty` are 0 and no entry is marked.
- R2: A request (`req_valid`) is answered one cycle later with `rsp_valid`=1. `rsp_skip` is 1 only if that block was already marked and still held. After the request the block is marked.
- R3: The entry index is `req_blk[5:0]` (likewise `snp_blk[5:0]`) and the tag is the remaining upper bits. A request whose tag differs from the stored tag answers `rsp_skip`=0 and takes over the entry. If the displaced entry was marked, the flag is set.
- R4: A snoop (`snp_valid`, covering remote writes and evictions) that hits a marked block with a matching tag clears that mark and sets the flag. A snoop to an unmarked block or to a different tag changes nothing.
- R5: `txn_clear` resets all marks and the flag in one cycle. A request in that cycle answers `rsp_skip`=0 and leaves no mark, and a snoop in that cycle is ignored.
- R6: `ctx_switch` clears all marks and sets the flag. It takes precedence over `txn_clear`, and requests and snoops in that cycle behave as under R5.
- R7: Once set, the flag stays set until a `txn_clear` without `ctx_switch`.
- R8: `qry_valid` is acknowledged one cycle later by `qry_ack`. `qry_dirty` then shows the flag after every event of the query cycle, including a snoop in that same cycle.
- R9: If a request and a hitting snoop target the same block in the same cycle, the answer is `rsp_skip`=0, the block ends up marked and the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Check-and-mark request |
| req_blk | input | 26 | Block number of the request |
| rsp_valid | output | 1 | Response to the request of the previous cycle |
| rsp_skip | output | 1 | 1: block already marked, do not log again |
| snp_valid | input | 1 | Remote write or eviction observed |
| snp_blk | input | 26 | Block number of the snooped event |
| txn_clear | input | 1 | Transaction begin: clear marks and flag |
| ctx_switch | input | 1 | Task switch: clear marks, set flag |
| qry_valid | input | 1 | Query of the possibly-written flag |
| qry_ack | output | 1 | Query answer valid |
| qry_dirty | output | 1 | Possibly-written flag |

## Verification
The bench builds the block with its default parameters: a 32-bit byte address, a 64-byte block and 64 entries. Random block numbers are confined to four indices and three tags. This keeps repeated hits, tag conflicts over marked entries, and snoops to marked blocks frequent. It also makes request/snoop collisions on the same block common enough to reach the precedence rules. Rare clears and context switches break the runs into many short transactions.

// File: rtl/rsf_pkg.sv
// Package: shared types for the read-set mark filter.
// Assumes: nothing beyond IEEE 1800-2017.
package rsf_pkg;

    // Result of looking up one table entry
    typedef struct packed {
        logic marked;     // entry carries a mark
        logic tag_match;  // stored tag equals the probing tag
    } probe_t;

endpackage

// File: rtl/rsf_mark_array.sv
// Module: direct-mapped table of mark bits and tags.
// Two read probes (request, snoop) and one update per cycle.
// Order within a cycle: wipe beats everything; a request set beats a snoop clear.
// Assumes: callers gate req_set/snp_clr with wipe and hit logic.
module rsf_mark_array
    import rsf_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             req_set,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic             snp_clr,
    output probe_t           req_probe,
    output probe_t           snp_probe
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] mark_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];

    // Combinational lookups for both ports
    always_comb begin
        req_probe.marked    = mark_q[req_idx];
        req_probe.tag_match = (tag_q[req_idx] == req_tag);
        snp_probe.marked    = mark_q[snp_idx];
        snp_probe.tag_match = (tag_q[snp_idx] == snp_tag);
    end

    // Mark bit update: reset/wipe, then snoop clear, then request set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_q <= '0;
        end else if (wipe) begin
            mark_q <= '0;
        end else begin
            if (snp_clr) mark_q[snp_idx] <= 1'b0;
            if (req_set) mark_q[req_idx] <= 1'b1;
        end
    end

    // Tag capture on every accepted request
    always_ff @(posedge clk) begin
        if (req_set) tag_q[req_idx] <= req_tag;
    end

    AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (mark_q == '0)); // R5
    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_set && !wipe) |=> mark_q[$past(req_idx)]); // R2
    AST_SNOOP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_clr && !wipe && !(req_set && req_idx == snp_idx)) |=> !mark_q[$past(snp_idx)]); // R4

endmodule

// File: rtl/rsf_sticky.sv
// Module: sticky "possibly written" flag.
// Priority: context switch sets, else clear resets, else raise sets, else hold.
// Assumes: raise is already gated off during clear/switch cycles.
module rsf_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic ctx_set,
    input  logic clr,
    input  logic raise,
    output logic flag
);
    // Flag register with set/clear priority
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (ctx_set) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
        else if (raise)   flag <= 1'b1;
    end

    AST_CTX_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_set |=> flag); // R6
    AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ctx_set) |=> !flag); // R5
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R7

endmodule

// File: rtl/rsf_readset_filter.sv
// Module: read-set mark filter top level.
// Splits block numbers into index and tag, resolves same-cycle races,
// registers the request and query responses, and drives the sticky flag.
// Assumes: block numbers arrive with the byte offset already removed.
module rsf_readset_filter
    import rsf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int IDX_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-OFF_W-1:0] req_blk,
    output logic                    rsp_valid,
    output logic                    rsp_skip,
    input  logic                    snp_valid,
    input  logic [ADDR_W-OFF_W-1:0] snp_blk,
    input  logic                    txn_clear,
    input  logic                    ctx_switch,
    input  logic                    qry_valid,
    output logic                    qry_ack,
    output logic                    qry_dirty
);
    localparam int BLK_W = ADDR_W - OFF_W;
    localparam int TAG_W = BLK_W - IDX_W;

    logic             wipe, req_go, snp_go;
    logic [IDX_W-1:0] req_idx, snp_idx;
    logic [TAG_W-1:0] req_tag, snp_tag;
    probe_t           req_probe, snp_probe;
    logic             req_hit, req_disp, snp_hit, race, skip_d, raise;

    // Address split and event gating
    always_comb begin
        wipe     = txn_clear | ctx_switch;
        req_go   = req_valid & ~wipe;
        snp_go   = snp_valid & ~wipe;
        req_idx  = req_blk[IDX_W-1:0];
        req_tag  = req_blk[BLK_W-1:IDX_W];
        snp_idx  = snp_blk[IDX_W-1:0];
        snp_tag  = snp_blk[BLK_W-1:IDX_W];
    end

    // Hit, displacement and race resolution
    always_comb begin
        req_hit  = req_probe.marked & req_probe.tag_match;
        req_disp = req_probe.marked & ~req_probe.tag_match;
        snp_hit  = snp_go & snp_probe.marked & snp_probe.tag_match;
        race     = snp_hit & (snp_idx == req_idx);
        skip_d   = req_go & req_hit & ~race;
        raise    = snp_hit | (req_go & req_disp);
    end

    rsf_mark_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_marks (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe      (wipe),
        .req_idx   (req_idx),
        .req_tag   (req_tag),
        .req_set   (req_go),
        .snp_idx   (snp_idx),
        .snp_tag   (snp_tag),
        .snp_clr   (snp_hit),
        .req_probe (req_probe),
        .snp_probe (snp_probe)
    );

    rsf_sticky i_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctx_set (ctx_switch),
        .clr     (txn_clear),
        .raise   (raise),
        .flag    (qry_dirty)
    );

    // Registered request and query responses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_skip  <= 1'b0;
            qry_ack   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_skip  <= skip_d;
            qry_ack   <= qry_valid;
        end
    end

    AST_SKIP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_skip |-> rsp_valid); // R2
    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_QRY_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        qry_valid |=> qry_ack); // R8
    AST_RACE_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && snp_valid && req_blk == snp_blk) |=> !rsp_skip); // R9

endmodule

// File: tb/test_rsf_readset_filter.sv
module test_rsf_readset_filter;
    localparam int CLK_PERIOD = 10;
    localparam int BLK_W = 26;
    localparam int IDX_W = 6;
    localparam int N     = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, snp_valid = 0, txn_clear = 0, ctx_switch = 0, qry_valid = 0;
    logic [BLK_W-1:0] req_blk = '0, snp_blk = '0;
    logic rsp_valid, rsp_skip, qry_ack, qry_dirty;

    int checks = 0;
    int errors = 0;

    // Reference state
    bit                   m_mark [N];
    bit [BLK_W-IDX_W-1:0] m_tag  [N];
    bit                   m_flag;
    bit e_rv, e_skip, e_qa;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsf_readset_filter i_rsf_readset_filter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_blk(req_blk),
        .rsp_valid(rsp_valid), .rsp_skip(rsp_skip),
        .snp_valid(snp_valid), .snp_blk(snp_blk),
        .txn_clear(txn_clear), .ctx_switch(ctx_switch),
        .qry_valid(qry_valid), .qry_ack(qry_ack), .qry_dirty(qry_dirty)
    );

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    function automatic logic [BLK_W-1:0] mk(int tag, int idx);
        return {tag[BLK_W-IDX_W-1:0], idx[IDX_W-1:0]};
    endfunction

    // Drive one cycle at the falling edge, update the model, check at the next falling edge
    task automatic step(string req, bit rv, logic [BLK_W-1:0] rb, bit sv,
                        logic [BLK_W-1:0] sb, bit clr, bit ctx, bit qv);
        int ri, si;
        bit wipe, hit, shit, disp;
        req_valid = rv; req_blk = rb; snp_valid = sv; snp_blk = sb;
        txn_clear = clr; ctx_switch = ctx; qry_valid = qv;
        ri = int'(rb[IDX_W-1:0]); si = int'(sb[IDX_W-1:0]);
        wipe = clr | ctx;
        hit  = m_mark[ri] && m_tag[ri] == rb[BLK_W-1:IDX_W];
        disp = m_mark[ri] && m_tag[ri] != rb[BLK_W-1:IDX_W];
        shit = sv && !wipe && m_mark[si] && m_tag[si] == sb[BLK_W-1:IDX_W];
        e_rv = rv; e_qa = qv;
        e_skip = rv && !wipe && hit && !(shit && si == ri);
        if (ctx || clr) begin
            foreach (m_mark[k]) m_mark[k] = 0;
            m_flag = ctx;
        end else begin
            if (shit) begin m_mark[si] = 0; m_flag = 1; end
            if (rv) begin
                if (disp) m_flag = 1;
                m_mark[ri] = 1; m_tag[ri] = rb[BLK_W-1:IDX_W];
            end
        end
        @(negedge clk);
        check(req, "rsp_valid", rsp_valid, e_rv);
        check(req, "rsp_skip",  rsp_skip,  e_skip);
        check("R8", "qry_ack",  qry_ack,   e_qa);
        check(req, "qry_dirty", qry_dirty, m_flag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        m_flag = 0;
        foreach (m_mark[k]) m_mark[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rsp_valid", rsp_valid, 1'b0);
        check("R1", "qry_ack",   qry_ack,   1'b0);
        check("R1", "qry_dirty", qry_dirty, 1'b0);

        // R1/R2: first touch not skipped, second touch skipped
        step("R1", 1, mk(1, 5), 0, '0, 0, 0, 1);
        step("R2", 1, mk(1, 5), 0, '0, 0, 0, 0);
        // R4: snoop to other tag: no effect; then hitting snoop
        step("R4", 0, '0, 1, mk(2, 5), 0, 0, 1);
        step("R4", 1, mk(1, 5), 0, '0, 0, 0, 0);
        step("R8", 0, '0, 1, mk(1, 5), 0, 0, 1);  // same-cycle snoop and query
        step("R7", 1, mk(1, 5), 0, '0, 0, 0, 1);
        // R5: clear, request during clear leaves no mark
        step("R5", 1, mk(1, 5), 1, mk(1, 5), 1, 0, 1);
        step("R5", 1, mk(1, 5), 0, '0, 0, 0, 0);
        step("R2", 1, mk(1, 5), 0, '0, 0, 0, 1);
        // R3: tag conflict displaces marked entry and sets flag
        step("R3", 1, mk(3, 5), 0, '0, 0, 0, 1);
        step("R3", 1, mk(1, 5), 0, '0, 0, 0, 0);
        // R6: context switch wins over clear
        step("R6", 1, mk(2, 9), 0, '0, 1, 1, 1);
        step("R6", 1, mk(2, 9), 0, '0, 0, 0, 1);
        step("R5", 0, '0, 0, '0, 1, 0, 1);
        // R9: request and hitting snoop on the same block
        step("R9", 1, mk(2, 9), 0, '0, 0, 0, 0);
        step("R9", 1, mk(2, 9), 1, mk(2, 9), 0, 0, 1);
        step("R9", 1, mk(2, 9), 0, '0, 0, 0, 0);

        // Constrained random phase
        for (int n = 0; n < 4000; n++) begin
            bit rv, sv, clr, ctx, qv;
            logic [BLK_W-1:0] rb, sb;
            rv  = ($urandom % 10) < 6;
            sv  = ($urandom % 10) < 3;
            clr = ($urandom % 100) < 3;
            ctx = ($urandom % 100) < 1;
            qv  = ($urandom % 10) < 3;
            rb  = mk(int'($urandom % 3), int'($urandom % 4));
            sb  = mk(int'($urandom % 3), int'($urandom % 4));
            step("R2", rv, rb, sv, sb, clr, ctx, qv);
        end
        step("R7", 0, '0, 0, '0, 0, 0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule